// File: doc/BRIEF.md
# Command Parity Fault Containment Controller

This block guards the start of DRAM accesses in a memory-card controller. Each clock cycle it checks the parity of the incoming 23-bit command bus. The bus carries 22 address bits and one parity bit. A parity check runs every cycle, even when no command is valid. If a fault is found, the block enters a lockdown state. In that state, accesses that have already begun row activation run to completion, while new accesses on both stacks are denied. Refresh keeps running as normal.

The access sequencer and the refresh engine are abstracted. Each stack raises a start request and later reports done. The block grants the start and tracks one in-flight access per stack. An active-low error output reports a fault to the system. A drain flag shows when all accesses that were already underway have finished. Lockdown and the error output stay asserted until reset.

Top module: `cmd_parity_guard`

## Requirements
- R1: While and right after reset, `err_n` is 1, `locked` is 0, `drained` is 0, and no stack is marked busy.
- R2: The parity check uses odd parity over all 23 bits: `cmd_bus[22]` is the parity bit and bits 21:0 are the address. If the bus holds an even number of ones, `locked` goes to 1 and `err_n` goes to 0 on the next clock edge. This happens whether or not any request is present.
- R3: When the block is not locked, the bus parity is good, and a stack is idle, `acc_req[s]` raises `acc_start[s]` in the same cycle. `acc_start` is never high without the matching request.
- R4: No `acc_start` is granted on any stack while `locked` is 1. No grant is given in a cycle whose bus parity is bad.
- R5: An access granted before the fault stays in flight until its `acc_done`. `drained` is 1 exactly when the block is locked and no stack is in flight. Once `drained` is set, it stays set.
- R6: `ref_start` follows `ref_req` in the same cycle, both before and after a fault.
- R7: `locked` and `err_n` hold their fault values until `rst_n` is low, even if the parity is good afterwards.
- R8: A stack with an access in flight gets no new start until its `acc_done`. An `acc_done` on an idle stack has no effect: a later request on that stack is still granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_bus | input | 23 | Command bus: bit 22 is odd parity, bits 21:0 are the address |
| acc_req | input | 2 | Per-stack request to begin an access |
| acc_done | input | 2 | Per-stack completion of an in-flight access |
| acc_start | output | 2 | Per-stack grant to begin row activation |
| ref_req | input | 1 | Refresh request |
| ref_start | output | 1 | Refresh grant |
| err_n | output | 1 | Active-low fault indication, held until reset |
| locked | output | 1 | Lockdown state |
| drained | output | 1 | Locked with no access in flight |

## Verification
The assertions assume that `acc_done` for a stack arrives only after that stack was granted a start. They also assume that `cmd_bus` is always driven to a known value, because the parity check does not depend on any valid signal. The stimulus raises done only on stacks it previously started, except in one directed case that checks an idle-stack done has no effect. It drives every bus value at the falling edge, so that each parity result is seen at exactly one rising edge.

// File: rtl/cmd_parity_guard.sv
module cmd_parity_guard #(
  parameter int ADDR_W = 22,
  parameter int STACKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W:0]   cmd_bus,
  input  logic [STACKS-1:0] acc_req,
  input  logic [STACKS-1:0] acc_done,
  output logic [STACKS-1:0] acc_start,
  input  logic              ref_req,
  output logic              ref_start,
  output logic              err_n,
  output logic              locked,
  output logic              drained
);

  logic              par_bad;
  logic              fault_q;
  logic              err_n_q;
  logic [STACKS-1:0] active_q;

  assign par_bad = ~(^cmd_bus);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      err_n_q <= 1'b1;
    end else if (par_bad) begin
      fault_q <= 1'b1;
      err_n_q <= 1'b0;
    end
  end

  assign acc_start = acc_req & ~active_q & {STACKS{~(fault_q | par_bad)}};

  for (genvar s = 0; s < STACKS; s++) begin : g_stack
    always_ff @(posedge clk) begin
      if (!rst_n)             active_q[s] <= 1'b0;
      else if (acc_start[s])  active_q[s] <= 1'b1;
      else if (acc_done[s])   active_q[s] <= 1'b0;
    end
  end

  assign ref_start = ref_req;
  assign err_n     = err_n_q;
  assign locked    = fault_q;
  assign drained   = fault_q & ~(|active_q);

endmodule

// File: rtl/cmd_parity_guard_chk.sv
module cmd_parity_guard_chk #(
  parameter int ADDR_W = 22,
  parameter int STACKS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W:0]   cmd_bus,
  input logic [STACKS-1:0] acc_req,
  input logic [STACKS-1:0] acc_done,
  input logic [STACKS-1:0] acc_start,
  input logic              ref_req,
  input logic              ref_start,
  input logic              err_n,
  input logic              locked,
  input logic              drained,
  input logic [STACKS-1:0] active_q
);

  a_r2_fault_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (^cmd_bus) == 1'b0 |=> locked && !err_n);

  a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start & ~acc_req) == '0);

  a_r4_no_start_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> acc_start == '0);

  a_r5_drain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    drained |=> drained);

  a_r6_refresh_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ref_req) |-> ref_start);

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && !err_n);

  a_r8_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start & active_q) == '0);

  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done & active_q & ~acc_start) != '0 |=> (active_q & $past(acc_done & active_q)) == '0);

endmodule

bind cmd_parity_guard cmd_parity_guard_chk #(.ADDR_W(ADDR_W), .STACKS(STACKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_bus(cmd_bus), .acc_req(acc_req), .acc_done(acc_done),
  .acc_start(acc_start), .ref_req(ref_req), .ref_start(ref_start), .err_n(err_n),
  .locked(locked), .drained(drained), .active_q(active_q)
);

// File: tb/cmd_parity_guard_bench.sv
module cmd_parity_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [22:0] cmd_bus = 23'h000001;
  logic [1:0]  acc_req = 2'b00;
  logic [1:0]  acc_done = 2'b00;
  logic        ref_req = 1'b0;
  logic [1:0]  acc_start;
  logic        ref_start, err_n, locked, drained;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cmd_parity_guard u_cmd_parity_guard (
    .clk(clk), .rst_n(rst_n), .cmd_bus(cmd_bus), .acc_req(acc_req), .acc_done(acc_done),
    .acc_start(acc_start), .ref_req(ref_req), .ref_start(ref_start), .err_n(err_n),
    .locked(locked), .drained(drained)
  );

  // {cmd, req, done, ref, exp_start, exp_ref, exp_locked, exp_err_n, exp_drained}
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {23'h000001, 2'b00, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},
    {23'h000001, 2'b01, 2'b00, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0},
    {23'h400000, 2'b11, 2'b00, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0},
    {23'h000001, 2'b00, 2'b01, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},
    {23'h000003, 2'b01, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0},
    {23'h000001, 2'b11, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0},
    {23'h000001, 2'b00, 2'b10, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {23'h000001, 2'b11, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1},
    {23'h000000, 2'b00, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [22:0] c, input logic [1:0] r, input logic [1:0] d, input logic f);
    @(negedge clk);
    cmd_bus = c; acc_req = r; acc_done = d; ref_req = f;
    #1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 locked in reset", {1'b0, locked}, 2'b00);
    check("R1 err_n in reset", {1'b0, err_n}, 2'b01);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][33:11], VEC[i][10:9], VEC[i][8:7], VEC[i][6]);
      check($sformatf("R3,R4,R8 start v%0d", i), acc_start, VEC[i][5:4]);
      check($sformatf("R6 ref v%0d", i), {1'b0, ref_start}, {1'b0, VEC[i][3]});
      check($sformatf("R2,R7 locked v%0d", i), {1'b0, locked}, {1'b0, VEC[i][2]});
      check($sformatf("R2,R7 err_n v%0d", i), {1'b0, err_n}, {1'b0, VEC[i][1]});
      check($sformatf("R5 drained v%0d", i), {1'b0, drained}, {1'b0, VEC[i][0]});
    end

    // R7 / R1: only reset leaves lockdown
    @(negedge clk) rst_n = 1'b0;
    drive(23'h000001, 2'b00, 2'b00, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 R7 locked cleared by reset", {1'b0, locked}, 2'b00);
    check("R1 err_n released by reset", {1'b0, err_n}, 2'b01);
    check("R1 drained after reset", {1'b0, drained}, 2'b00);

    // R2: 22 address ones, parity 0 -> bad, with no request present
    drive(23'h3FFFFF, 2'b00, 2'b00, 1'b0);
    check("R2 not locked before edge", {1'b0, locked}, 2'b00);
    drive(23'h7FFFFF, 2'b00, 2'b00, 1'b0);
    check("R2 locked without request", {1'b0, locked}, 2'b01);
    check("R2 err_n low", {1'b0, err_n}, 2'b00);
    for (int k = 0; k < 5; k++) drive(23'h7FFFFF, 2'b11, 2'b00, 1'b0);
    check("R7 lock holds on good parity", {1'b0, locked}, 2'b01);
    check("R4 no start while locked", acc_start, 2'b00);
    check("R5 drained with nothing in flight", {1'b0, drained}, 2'b01);

    // R2: all ones is good parity; R8 idle done ignored
    @(negedge clk) rst_n = 1'b0;
    drive(23'h7FFFFF, 2'b00, 2'b00, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    drive(23'h7FFFFF, 2'b00, 2'b11, 1'b0);
    check("R2 all-ones bus is good", {1'b0, locked}, 2'b00);
    drive(23'h7FFFFF, 2'b11, 2'b00, 1'b0);
    check("R8 idle done ignored, R3 grant", acc_start, 2'b11);
    drive(23'h7FFFFF, 2'b11, 2'b00, 1'b0);
    check("R8 no second start in flight", acc_start, 2'b00);
    drive(23'h7FFFFF, 2'b00, 2'b01, 1'b0);
    drive(23'h7FFFFF, 2'b11, 2'b00, 1'b0);
    check("R8 restart after done", acc_start, 2'b01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule